// File: doc/BRIEF.md
# Permutation-Coded Least-Recently-Used Way Tracker

This block holds the complete recency order of the ways in every set of a 3-way or 4-way set-associative cache. Each set keeps a single small code that numbers one permutation of its ways. A cache controller presents a set index. It reads back the way to evict for that set, and it pulses an access strobe with the way that hit or was just filled. A lock floor input names the lowest way that may be replaced, so that ways below it can stay resident.

The access interface is a plain strobe and not a valid/ready stream. Every strobe is taken in the cycle it is presented, so the block never applies back-pressure. The victim output and the current code follow the addressed set combinationally. An update is written on the rising clock edge.

A code value that no permutation uses cannot arise from reset and accesses. If one is present anyway, the update logic treats it as the fully descending order. For four ways, such a code reports way 0 as the victim.

Top module: `lru_perm_tracker`

## Requirements
- R1: With WAYS=3 the code is 3 bits wide. It ranks the order, written from least to most recently used, lexicographically among the six orders. Examples: 0-1-2 is 0, 0-2-1 is 1, 1-2-0 is 3, 2-1-0 is 5.
- R2: With WAYS=4 the code is 5 bits wide and ranks the 24 orders the same way. Examples: 0-1-2-3 is 0, 1-2-3-0 is 9, 3-2-1-0 is 23. Every one of the 24 codes can be reached by accesses.
- R3: An access to a valid way moves that way to the most recently used position and keeps the relative order of the others. With 4 ways, an access to way 0 in state 0-1-2-3 gives 1-2-3-0.
- R4: An access whose way index is not below WAYS leaves the set's code unchanged.
- R5: The victim is the least recently used way among the ways whose index is greater than or equal to the lock floor. With 3 ways in state 0-2-1 and a floor of 1, the victim is way 2.
- R6: A lock floor at or above WAYS-1 always gives victim WAYS-1.
- R7: After reset, every set holds code 0.
- R8: Both outputs are combinational from the stored code of the addressed set. In a cycle that carries an access, they show the state from before the update. Without the strobe the code does not change.
- R9: An access changes only the set named by the set index. All other sets keep their codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_idx | input | SET_W | Set addressed for the victim read and for the update |
| acc_en | input | 1 | Access strobe; the update is written at the next rising edge |
| acc_way | input | WAY_W | Way that hit or was filled |
| floor_way | input | WAY_W | Lowest way allowed for replacement |
| victim_way | output | WAY_W | Way to replace in the addressed set |
| cur_code | output | CODE_W | Stored order code of the addressed set |

## Verification
The assertions assume that set_idx, acc_en, acc_way and floor_way hold defined values and stay steady around each rising edge. The properties that compare a cycle with the previous one also assume that the strobe was taken against the same set that is addressed on the following cycle. The stimulus changes every input only on the falling edge and keeps every input at a known value, including during reset. It drives one stimulus stream into a 4-way and a 3-way instance at once. Way 3 is therefore an out-of-range way for the 3-way instance, and a floor of 3 lies above its highest way.

// File: rtl/lru_perm_pkg.sv
`timescale 1ns/1ps
package lru_perm_pkg;

  // Number of orderings of n ways (n factorial).
  function automatic int perm_total(input int n);
    int r;
    r = 1;
    for (int k = 2; k <= n; k++) r = r * k;
    return r;
  endfunction

endpackage

// File: rtl/lru_perm_decode.sv
`timescale 1ns/1ps
// Turns a ranked permutation code into an ordered way list (index 0 = LRU).
module lru_perm_decode import lru_perm_pkg::*; #(
  parameter  int WAYS   = 4,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int CODE_W = $clog2(perm_total(WAYS))
) (
  input  logic [CODE_W-1:0]           code_i,
  output logic [WAYS-1:0][WAY_W-1:0]  order_o,
  output logic                        bad_o
);
  localparam int NPERM = perm_total(WAYS);

  always_comb begin
    int rem;
    int digit;
    int fw;
    int seen;
    logic got;
    logic [WAYS-1:0] taken;
    order_o = '0;
    taken   = '0;
    rem     = int'(code_i);
    bad_o   = (rem >= NPERM);
    for (int i = 0; i < WAYS; i++) begin
      fw    = perm_total(WAYS - 1 - i);
      digit = rem / fw;
      rem   = rem % fw;
      seen  = 0;
      got   = 1'b0;
      // pick the digit-th way that is still free, counting upward
      for (int j = 0; j < WAYS; j++) begin
        if (!taken[j]) begin
          if (!got && seen == digit) begin
            order_o[i] = WAY_W'(j);
            taken[j]   = 1'b1;
            got        = 1'b1;
          end
          seen = seen + 1;
        end
      end
    end
    // unused codes act as the fully descending order
    if (bad_o) begin
      for (int i = 0; i < WAYS; i++) order_o[i] = WAY_W'(WAYS - 1 - i);
    end
  end

endmodule

// File: rtl/lru_perm_encode.sv
`timescale 1ns/1ps
// Ranks an ordered way list lexicographically among all orderings.
module lru_perm_encode import lru_perm_pkg::*; #(
  parameter  int WAYS   = 4,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int CODE_W = $clog2(perm_total(WAYS))
) (
  input  logic [WAYS-1:0][WAY_W-1:0] order_i,
  output logic [CODE_W-1:0]          code_o
);

  always_comb begin
    int acc;
    int smaller;
    acc = 0;
    for (int i = 0; i < WAYS; i++) begin
      smaller = 0;
      for (int j = i + 1; j < WAYS; j++) begin
        if (order_i[j] < order_i[i]) smaller = smaller + 1;
      end
      acc = acc + smaller * perm_total(WAYS - 1 - i);
    end
    code_o = CODE_W'(acc);
  end

endmodule

// File: rtl/lru_perm_promote.sv
`timescale 1ns/1ps
// Moves the accessed way to the MRU end, keeping the others in order.
module lru_perm_promote #(
  parameter  int WAYS  = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][WAY_W-1:0] order_i,
  input  logic                       en_i,
  input  logic [WAY_W-1:0]           way_i,
  output logic [WAYS-1:0][WAY_W-1:0] order_o,
  output logic                       moved_o
);

  always_comb begin
    logic hit;
    int   pos;
    hit = 1'b0;
    pos = WAYS - 1;
    // a way index outside the list never matches, so it is ignored
    for (int i = 0; i < WAYS; i++) begin
      if (!hit && order_i[i] == way_i) begin
        hit = 1'b1;
        pos = i;
      end
    end
    hit = hit & en_i;
    for (int i = 0; i < WAYS - 1; i++) begin
      order_o[i] = (hit && i >= pos) ? order_i[i+1] : order_i[i];
    end
    order_o[WAYS-1] = hit ? way_i : order_i[WAYS-1];
    moved_o = hit;
  end

endmodule

// File: rtl/lru_victim_pick.sv
`timescale 1ns/1ps
// Least recently used way at or above the lock floor.
module lru_victim_pick #(
  parameter  int WAYS  = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][WAY_W-1:0] order_i,
  input  logic                       bad_i,
  input  logic [WAY_W-1:0]           floor_i,
  output logic [WAY_W-1:0]           victim_o
);
  localparam logic [WAY_W-1:0] TOP = WAY_W'(WAYS - 1);
  localparam bit BAD_ZERO = (WAYS == 4);

  logic [WAY_W-1:0] lim;

  generate
    if (WAYS == (1 << WAY_W)) begin : g_full
      assign lim = floor_i;
    end else begin : g_clamp
      assign lim = (floor_i > TOP) ? TOP : floor_i;
    end
  endgenerate

  always_comb begin
    victim_o = TOP;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (order_i[i] >= lim) victim_o = order_i[i];
    end
    if (BAD_ZERO && bad_i) victim_o = '0;
  end

endmodule

// File: rtl/lru_perm_tracker.sv
`timescale 1ns/1ps
module lru_perm_tracker import lru_perm_pkg::*; #(
  parameter  int WAYS   = 4,
  parameter  int SETS   = 16,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int SET_W  = $clog2(SETS),
  localparam int CODE_W = $clog2(perm_total(WAYS))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  set_idx,
  input  logic              acc_en,
  input  logic [WAY_W-1:0]  acc_way,
  input  logic [WAY_W-1:0]  floor_way,
  output logic [WAY_W-1:0]  victim_way,
  output logic [CODE_W-1:0] cur_code
);

  logic [SETS-1:0][CODE_W-1:0]  code_all;
  logic [CODE_W-1:0]            code_rd;
  logic [CODE_W-1:0]            code_nx;
  logic [WAYS-1:0][WAY_W-1:0]   ord_now;
  logic [WAYS-1:0][WAY_W-1:0]   ord_nx;
  logic                         bad_code;
  logic                         wr_en;

  assign code_rd = code_all[set_idx];

  lru_perm_decode #(.WAYS(WAYS)) u_dec (
    .code_i  (code_rd),
    .order_o (ord_now),
    .bad_o   (bad_code)
  );

  lru_perm_promote #(.WAYS(WAYS)) u_pro (
    .order_i (ord_now),
    .en_i    (acc_en),
    .way_i   (acc_way),
    .order_o (ord_nx),
    .moved_o (wr_en)
  );

  lru_perm_encode #(.WAYS(WAYS)) u_enc (
    .order_i (ord_nx),
    .code_o  (code_nx)
  );

  lru_victim_pick #(.WAYS(WAYS)) u_vic (
    .order_i  (ord_now),
    .bad_i    (bad_code),
    .floor_i  (floor_way),
    .victim_o (victim_way)
  );

  generate
    for (genvar s = 0; s < SETS; s++) begin : g_set
      logic [CODE_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
        end else if (wr_en && set_idx == SET_W'(s)) begin
          q <= code_nx;
        end
      end
      assign code_all[s] = q;
    end
  endgenerate

  assign cur_code = code_rd;

endmodule

// File: rtl/lru_perm_tracker_chk.sv
`timescale 1ns/1ps
module lru_perm_tracker_chk import lru_perm_pkg::*; #(
  parameter  int WAYS   = 4,
  parameter  int SETS   = 16,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int SET_W  = $clog2(SETS),
  localparam int CODE_W = $clog2(perm_total(WAYS))
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SET_W-1:0]  set_idx,
  input logic              acc_en,
  input logic [WAY_W-1:0]  acc_way,
  input logic [WAY_W-1:0]  floor_way,
  input logic [WAY_W-1:0]  victim_way,
  input logic [CODE_W-1:0] cur_code
);
  localparam int NPERM = perm_total(WAYS);

  logic live;
  int   fl_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  always_comb begin
    fl_lim = (int'(floor_way) >= WAYS - 1) ? WAYS - 1 : int'(floor_way);
  end

  AST_VICTIM_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(victim_way) >= fl_lim) && (int'(victim_way) < WAYS)); // R5

  AST_TOP_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(floor_way) >= WAYS - 1) |-> (int'(victim_way) == WAYS - 1)); // R6

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cur_code) < NPERM); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !$past(acc_en) && set_idx == $past(set_idx)) |-> $stable(cur_code)); // R8

  AST_BAD_WAY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(acc_en) && int'($past(acc_way)) >= WAYS && set_idx == $past(set_idx))
      |-> $stable(cur_code)); // R4

  AST_MRU_SPARED: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(acc_en) && int'($past(acc_way)) < WAYS && set_idx == $past(set_idx)
      && fl_lim < WAYS - 1) |-> (victim_way != $past(acc_way))); // R3

endmodule

bind lru_perm_tracker lru_perm_tracker_chk #(.WAYS(WAYS), .SETS(SETS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .set_idx    (set_idx),
  .acc_en     (acc_en),
  .acc_way    (acc_way),
  .floor_way  (floor_way),
  .victim_way (victim_way),
  .cur_code   (cur_code)
);

// File: tb/lru_perm_tracker_test.sv
`timescale 1ns/1ps
module lru_perm_tracker_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n;
  logic [1:0] set_idx, acc_way, floor_way;
  logic       acc_en;
  logic [1:0] vic4, vic3;
  logic [4:0] code4;
  logic [2:0] code3;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int mdl [2][4][4];   // [instance][set][position], position 0 = LRU
  bit seen4 [32];
  bit seen3 [8];

  lru_perm_tracker #(.WAYS(4), .SETS(4)) uut (
    .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .acc_en(acc_en),
    .acc_way(acc_way), .floor_way(floor_way), .victim_way(vic4), .cur_code(code4));

  lru_perm_tracker #(.WAYS(3), .SETS(4)) uut3 (
    .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .acc_en(acc_en),
    .acc_way(acc_way), .floor_way(floor_way), .victim_way(vic3), .cur_code(code3));

  function automatic int nw(int k);
    return (k == 0) ? 4 : 3;
  endfunction

  // Lehmer rank by Horner's rule
  function automatic int ref_code(int k, int s);
    int n, acc, sm;
    n = nw(k);
    acc = 0;
    for (int i = 0; i < n; i++) begin
      sm = 0;
      for (int j = i + 1; j < n; j++) if (mdl[k][s][j] < mdl[k][s][i]) sm++;
      acc = acc * (n - i) + sm;
    end
    return acc;
  endfunction

  function automatic int ref_victim(int k, int s, int f);
    int n, fl;
    n = nw(k);
    fl = (f > n - 1) ? n - 1 : f;
    for (int i = 0; i < n; i++) if (mdl[k][s][i] >= fl) return mdl[k][s][i];
    return -1;
  endfunction

  function automatic void ref_access(int k, int s, int w);
    int n, p;
    n = nw(k);
    if (w >= n) return;
    p = 0;
    for (int i = 0; i < n; i++) if (mdl[k][s][i] == w) p = i;
    for (int i = p; i < n - 1; i++) mdl[k][s][i] = mdl[k][s][i+1];
    mdl[k][s][n-1] = w;
  endfunction

  function automatic string vtag(int k, int f, bit en);
    if (f >= nw(k) - 1) return "R6";
    if (en) return "R8";
    return "R5";
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic peek(int s, int f);
    @(negedge clk);
    set_idx = 2'(s); acc_en = 1'b0; acc_way = 2'd0; floor_way = 2'(f);
    #0.4;
  endtask

  // Present one cycle of stimulus; sweep all floors before the edge.
  task automatic step(int s, bit en, int w);
    @(negedge clk);
    set_idx = 2'(s); acc_en = en; acc_way = 2'(w);
    for (int f = 0; f < 4; f++) begin
      floor_way = 2'(f);
      #0.4;
      if (f == 0) begin
        chk("R3", int'(code4), ref_code(0, s));
        chk("R3", int'(code3), ref_code(1, s));
      end
      chk(vtag(0, f, en), int'(vic4), ref_victim(0, s, f));
      chk(vtag(1, f, en), int'(vic3), ref_victim(1, s, f));
    end
    seen4[code4] = 1'b1;
    seen3[code3] = 1'b1;
    @(posedge clk);
    if (en) begin
      ref_access(0, s, w);
      ref_access(1, s, w);
    end
  endtask

  initial begin
    logic [15:0] lfsr;
    int cnt;
    rst_n = 1'b0; set_idx = '0; acc_en = 1'b0; acc_way = '0; floor_way = '0;
    for (int k = 0; k < 2; k++)
      for (int s = 0; s < 4; s++)
        for (int i = 0; i < 4; i++) mdl[k][s][i] = i;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R7: every set starts at code 0
    for (int s = 0; s < 4; s++) begin
      peek(s, 0);
      chk("R7", int'(code4), 0);
      chk("R7", int'(code3), 0);
    end

    // R2 / R1 encoding examples
    step(1, 1'b1, 0);
    peek(1, 0);
    chk("R2", int'(code4), 9);
    chk("R1", int'(code3), 3);

    // R5 example: 3-way order 0-2-1, floor 1 -> way 2
    step(2, 1'b1, 2);
    step(2, 1'b1, 1);
    peek(2, 1);
    chk("R1", int'(code3), 1);
    chk("R5", int'(vic3), 2);

    // R4: way 3 is outside the 3-way instance
    step(3, 1'b1, 3);
    peek(3, 0);
    chk("R4", int'(code3), 0);
    step(3, 1'b1, 2);
    step(3, 1'b1, 1);
    step(3, 1'b1, 0);
    peek(3, 0);
    chk("R2", int'(code4), 23);
    chk("R1", int'(code3), 5);

    // R6: top floor always names the highest way
    peek(2, 3);
    chk("R6", int'(vic4), 3);
    chk("R6", int'(vic3), 2);

    // R9: set 0 untouched by accesses elsewhere
    peek(0, 0);
    chk("R9", int'(code4), 0);
    chk("R9", int'(code3), 0);

    // R8: victim before the edge reflects the old order
    @(negedge clk);
    set_idx = 2'd1; acc_en = 1'b1; acc_way = 2'd1; floor_way = 2'd0;
    #0.4;
    chk("R8", int'(vic4), 1);
    chk("R8", int'(vic3), 1);
    @(posedge clk);
    ref_access(0, 1, 1);
    ref_access(1, 1, 1);
    peek(1, 0);
    chk("R8", int'(vic4), 2);
    chk("R8", int'(vic3), 2);
    peek(1, 0);
    chk("R8", int'(code4), ref_code(0, 1));

    // Long pseudo-random walk over all sets, ways and floors
    lfsr = 16'hACE1;
    for (int t = 0; t < 1500; t++) begin
      lfsr = {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
      step(int'(lfsr[1:0]), lfsr[4] | lfsr[5], int'(lfsr[3:2]));
    end

    // R9: final sweep of every set against the model
    for (int s = 0; s < 4; s++) begin
      peek(s, 0);
      chk("R9", int'(code4), ref_code(0, s));
      chk("R9", int'(code3), ref_code(1, s));
    end

    cnt = 0;
    for (int c = 0; c < 32; c++) if (seen4[c]) cnt++;
    chk("R2", cnt, 24);
    cnt = 0;
    for (int c = 0; c < 8; c++) if (seen3[c]) cnt++;
    chk("R1", cnt, 6);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule